// File: doc/BRIEF.md
# Three-Channel Timer Register Port

This block is the byte-wide access port that sits between a processor bus and three interval-timer channels. A two-bit address selects one of three per-channel count ports (addresses 0, 1 and 2) or the shared command register (address 3). Software writes command bytes to program a channel's byte access order, counting mode and decimal flag. It can also freeze a channel's count or status for later reading, and it moves the 16-bit count through the 8-bit data path one byte at a time.

The counters themselves live outside this block. On a completed count write the port raises a one-cycle load strobe with a 16-bit value for the channel. It reads each channel's running count and output level from input buses. It presents each channel's programmed counting mode and decimal flag as outputs. Every channel keeps its own byte pointers for reads and for writes, its own frozen-count holding register and its own frozen-status holding register.

Top module: `tmrPort`

## Requirements
- R1: After reset every channel uses low-then-high byte access, counting mode 0 and binary counting. No count or status is held, and both byte pointers point to the low byte.
- R2: A command byte with bits 7:6 = channel 0..2 and bits 5:4 non-zero sets that channel's access order (1 = low byte only, 2 = high byte only, 3 = low then high). It also sets the counting mode from bits 3:1, with 6 and 7 folded to 2 and 3, and the decimal flag from bit 0. chanMode and chanBcd show the new values from the next clock edge, and both byte pointers of the channel return to the low byte.
- R3: In low-only access a count write loads {8'h00, byte}, and in high-only access it loads {byte, 8'h00}. loadStrobe has exactly the bit of the written channel high during the cycle of the write, and is never high without a write to that channel.
- R4: In low-then-high access the first count byte only lands in a holding register and causes no load. The second byte loads {second, first}, and the write pointer then returns to the low byte.
- R5: With nothing held, a read returns the live count: low byte in low-only access, high byte in high-only access, and alternately low then high in low-then-high access. A read of address 3 returns 8'h00.
- R6: A command byte with bits 5:4 = 0 and bits 7:6 = channel freezes that channel's live count at the clock edge of the write and leaves its access order unchanged. Later reads return the frozen bytes in the channel's access order, and the hold is released after the last byte.
- R7: A request to freeze a count is ignored while an earlier frozen count of that channel is still unread, and the same holds for status.
- R8: A command byte with bits 7:6 = 3 acts on every channel whose select bit is 1 (bit 1 = channel 0, bit 2 = channel 1, bit 3 = channel 2). Bit 5 = 0 freezes the count and bit 4 = 0 freezes the status, for all selected channels in the same edge.
- R9: A frozen status byte is {output level at the freeze edge, 1'b0, access order[1:0], counting mode[2:0], decimal flag}.
- R10: A read returns a held status byte first, then a held count, and the live count only when nothing is held. Each read consumes only the item it returned.
- R11: A read access ends on the first clock edge at which rdEn is low after being high. rdData follows only addr, the live inputs and the port state, and the port state moves only at that ending edge, so rdData holds still for as long as rdEn stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | 0..2 channel count port, 3 command register |
| wrData | input | 8 | Write byte |
| wrEn | input | 1 | Write strobe, one write per cycle high |
| rdEn | input | 1 | Read strobe, one read per high pulse |
| rdData | output | 8 | Read byte |
| loadStrobe | output | 3 | Per-channel count load pulse |
| loadValue | output | 48 | Per-channel 16-bit count to load |
| liveCount | input | 48 | Per-channel running count from the counters |
| timerOut | input | 3 | Per-channel output level from the counters |
| chanMode | output | 9 | Per-channel 3-bit counting mode |
| chanBcd | output | 3 | Per-channel decimal counting flag |

## Verification
The hardest state to reach is one where a channel holds both a frozen status and a frozen count while its live byte pointer sits half-way through a word. The port must then return status, count low and count high, and only after that resume the live high byte. The directed part builds this by reading one live low byte, then issuing a multi-channel freeze command and changing the live counts before reading. The random part mixes command bytes, count writes, reads and live-value changes so that frozen items, repeated freeze requests and pointer positions overlap across all three channels.

// File: rtl/tmrPortPkg.sv
package tmrPortPkg;
  localparam int NUM_CH = 3;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_FREEZE = 2'd0,
    ACC_LO     = 2'd1,
    ACC_HI     = 2'd2,
    ACC_WORD   = 2'd3
  } accMode_e;

  // strobes from the control decoder to one channel's datapath
  typedef struct packed {
    logic setCtrl;
    logic latchCnt;
    logic latchStat;
    logic wrByte;
    logic rdDone;
  } chanStrobe_t;
endpackage

// File: rtl/tmrPortCtl.sv
module tmrPortCtl
  import tmrPortPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               addr,
  input  logic [BYTE_W-1:0]        wrData,
  input  logic                     wrEn,
  input  logic                     rdEn,
  output chanStrobe_t [NUM_CH-1:0] strobes
);
  logic       rdPrev;
  logic [1:0] rdAddrQ;
  logic       rdEnd;
  logic       isCmd;
  logic       isReadBack;

  // a read completes on the edge that sees the strobe drop
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev  <= 1'b0;
      rdAddrQ <= 2'd0;
    end else begin
      rdPrev <= rdEn;
      if (rdEn) rdAddrQ <= addr;
    end
  end

  assign rdEnd      = rdPrev && !rdEn;
  assign isCmd      = wrEn && (addr == 2'd3);
  assign isReadBack = (wrData[7:6] == 2'd3);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    localparam logic [1:0] CH = 2'(i);
    logic selMe;
    logic rbMe;
    assign selMe = isCmd && !isReadBack && (wrData[7:6] == CH);
    assign rbMe  = isCmd && isReadBack && wrData[i+1];

    assign strobes[i].setCtrl   = selMe && (wrData[5:4] != ACC_FREEZE);
    assign strobes[i].latchCnt  = (selMe && (wrData[5:4] == ACC_FREEZE)) || (rbMe && !wrData[5]);
    assign strobes[i].latchStat = rbMe && !wrData[4];
    assign strobes[i].wrByte    = wrEn && (addr == CH);
    assign strobes[i].rdDone    = rdEnd && (rdAddrQ == CH);
  end
endmodule

// File: rtl/tmrPortData.sv
module tmrPortData
  import tmrPortPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 addr,
  input  logic [BYTE_W-1:0]          wrData,
  input  chanStrobe_t [NUM_CH-1:0]   strobes,
  input  logic [NUM_CH*CNT_W-1:0]    liveCount,
  input  logic [NUM_CH-1:0]          timerOut,
  output logic [BYTE_W-1:0]          rdData,
  output logic [NUM_CH-1:0]          loadStrobe,
  output logic [NUM_CH*CNT_W-1:0]    loadValue,
  output logic [NUM_CH*MODE_W-1:0]   chanMode,
  output logic [NUM_CH-1:0]          chanBcd,
  output logic [NUM_CH-1:0]          statHeld,
  output logic [NUM_CH-1:0]          cntHeld,
  output logic [NUM_CH*CNT_W-1:0]    cntHeldVal
);
  logic [BYTE_W-1:0] chanByte [NUM_CH];
  logic [MODE_W-1:0] modeFix;

  // counting modes 6 and 7 fold onto 2 and 3
  assign modeFix = (wrData[3:1] > 3'd5) ? {1'b0, wrData[2:1]} : wrData[3:1];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    chanStrobe_t       st;
    logic [CNT_W-1:0]  live;
    logic [1:0]        accQ;
    logic [MODE_W-1:0] modeQ;
    logic              bcdQ;
    logic              wrHiQ;
    logic              rdHiQ;
    logic [BYTE_W-1:0] holdQ;
    logic              cntHeldQ;
    logic [1:0]        cntModeQ;
    logic [CNT_W-1:0]  cntValQ;
    logic              statHeldQ;
    logic [BYTE_W-1:0] statQ;

    assign st   = strobes[i];
    assign live = liveCount[i*CNT_W +: CNT_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        accQ      <= ACC_WORD;
        modeQ     <= '0;
        bcdQ      <= 1'b0;
        wrHiQ     <= 1'b0;
        rdHiQ     <= 1'b0;
        holdQ     <= '0;
        cntHeldQ  <= 1'b0;
        cntModeQ  <= ACC_WORD;
        cntValQ   <= '0;
        statHeldQ <= 1'b0;
        statQ     <= '0;
      end else begin
        // read completion consumes the item that was shown
        if (st.rdDone) begin
          if (statHeldQ) begin
            statHeldQ <= 1'b0;
          end else if (cntHeldQ) begin
            if (cntModeQ == ACC_WORD) cntModeQ <= ACC_HI;
            else                      cntHeldQ <= 1'b0;
          end else if (accQ == ACC_WORD) begin
            rdHiQ <= !rdHiQ;
          end
        end
        // freeze requests are dropped while an older one is unread
        if (st.latchCnt && !cntHeldQ) begin
          cntHeldQ <= 1'b1;
          cntModeQ <= accQ;
          cntValQ  <= live;
        end
        if (st.latchStat && !statHeldQ) begin
          statHeldQ <= 1'b1;
          statQ     <= {timerOut[i], 1'b0, accQ, modeQ, bcdQ};
        end
        // programming and count writes
        if (st.setCtrl) begin
          accQ  <= wrData[5:4];
          modeQ <= modeFix;
          bcdQ  <= wrData[0];
          wrHiQ <= 1'b0;
          rdHiQ <= 1'b0;
        end else if (st.wrByte && (accQ == ACC_WORD)) begin
          if (!wrHiQ) holdQ <= wrData;
          wrHiQ <= !wrHiQ;
        end
      end
    end

    assign loadStrobe[i] = st.wrByte && ((accQ != ACC_WORD) || wrHiQ);

    always_comb begin
      unique case (accQ)
        ACC_LO:  loadValue[i*CNT_W +: CNT_W] = {{BYTE_W{1'b0}}, wrData};
        ACC_HI:  loadValue[i*CNT_W +: CNT_W] = {wrData, {BYTE_W{1'b0}}};
        default: loadValue[i*CNT_W +: CNT_W] = {wrData, holdQ};
      endcase
    end

    always_comb begin
      if (statHeldQ)
        chanByte[i] = statQ;
      else if (cntHeldQ)
        chanByte[i] = (cntModeQ == ACC_HI) ? cntValQ[CNT_W-1:BYTE_W] : cntValQ[BYTE_W-1:0];
      else if ((accQ == ACC_HI) || ((accQ == ACC_WORD) && rdHiQ))
        chanByte[i] = live[CNT_W-1:BYTE_W];
      else
        chanByte[i] = live[BYTE_W-1:0];
    end

    assign chanMode[i*MODE_W +: MODE_W]  = modeQ;
    assign chanBcd[i]                    = bcdQ;
    assign statHeld[i]                   = statHeldQ;
    assign cntHeld[i]                    = cntHeldQ;
    assign cntHeldVal[i*CNT_W +: CNT_W]  = cntValQ;
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_CH; k++)
      if (addr == 2'(k)) rdData = chanByte[k];
  end
endmodule

// File: rtl/tmrPort.sv
module tmrPort
  import tmrPortPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               addr,
  input  logic [BYTE_W-1:0]        wrData,
  input  logic                     wrEn,
  input  logic                     rdEn,
  output logic [BYTE_W-1:0]        rdData,
  output logic [NUM_CH-1:0]        loadStrobe,
  output logic [NUM_CH*CNT_W-1:0]  loadValue,
  input  logic [NUM_CH*CNT_W-1:0]  liveCount,
  input  logic [NUM_CH-1:0]        timerOut,
  output logic [NUM_CH*MODE_W-1:0] chanMode,
  output logic [NUM_CH-1:0]        chanBcd
);
  chanStrobe_t [NUM_CH-1:0] strobes;
  logic [NUM_CH-1:0]        statHeld;
  logic [NUM_CH-1:0]        cntHeld;
  logic [NUM_CH*CNT_W-1:0]  cntHeldVal;

  tmrPortCtl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .wrData  (wrData),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .strobes (strobes)
  );

  tmrPortData u_data (
    .clk        (clk),
    .rstN       (rstN),
    .addr       (addr),
    .wrData     (wrData),
    .strobes    (strobes),
    .liveCount  (liveCount),
    .timerOut   (timerOut),
    .rdData     (rdData),
    .loadStrobe (loadStrobe),
    .loadValue  (loadValue),
    .chanMode   (chanMode),
    .chanBcd    (chanBcd),
    .statHeld   (statHeld),
    .cntHeld    (cntHeld),
    .cntHeldVal (cntHeldVal)
  );
endmodule

// File: rtl/tmrPortChecker.sv
module tmrPortChecker
  import tmrPortPkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [1:0]               addr,
  input logic [BYTE_W-1:0]        wrData,
  input logic                     wrEn,
  input logic                     rdEn,
  input logic [BYTE_W-1:0]        rdData,
  input logic [NUM_CH-1:0]        loadStrobe,
  input logic [NUM_CH*CNT_W-1:0]  liveCount,
  input logic [NUM_CH-1:0]        timerOut,
  input logic [NUM_CH*MODE_W-1:0] chanMode,
  input logic [NUM_CH-1:0]        chanBcd,
  input logic [NUM_CH-1:0]        statHeld,
  input logic [NUM_CH-1:0]        cntHeld,
  input logic [NUM_CH*CNT_W-1:0]  cntHeldVal
);
  p_load_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadStrobe));

  p_read_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn) && !$past(wrEn) && $stable(addr) &&
     $stable(liveCount) && $stable(timerOut)) |-> $stable(rdData));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    localparam logic [1:0] CH = 2'(i);

    p_load_on_write_r3: assert property (@(posedge clk) disable iff (!rstN)
      loadStrobe[i] |-> (wrEn && (addr == CH)));

    p_mode_update_r2: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && (addr == 2'd3) && (wrData[7:6] == CH) && (wrData[5:4] != 2'd0))
      |=> ((chanMode[i*MODE_W +: 2] == $past(wrData[2:1])) && (chanBcd[i] == $past(wrData[0]))));

    p_status_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      (statHeld[i] && !($past(rdEn) && !rdEn)) |=> statHeld[i]);

    p_count_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      (cntHeld[i] && !($past(rdEn) && !rdEn))
      |=> (cntHeld[i] && $stable(cntHeldVal[i*CNT_W +: CNT_W])));
  end
endmodule

bind tmrPort tmrPortChecker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .addr       (addr),
  .wrData     (wrData),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .rdData     (rdData),
  .loadStrobe (loadStrobe),
  .liveCount  (liveCount),
  .timerOut   (timerOut),
  .chanMode   (chanMode),
  .chanBcd    (chanBcd),
  .statHeld   (statHeld),
  .cntHeld    (cntHeld),
  .cntHeldVal (cntHeldVal)
);

// File: tb/tb_tmrPort.sv
module tb_tmrPort;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  addr;
  logic [7:0]  wrData;
  logic        wrEn;
  logic        rdEn;
  logic [7:0]  rdData;
  logic [2:0]  loadStrobe;
  logic [47:0] loadValue;
  logic [47:0] liveCount;
  logic [2:0]  timerOut;
  logic [8:0]  chanMode;
  logic [2:0]  chanBcd;

  logic [15:0] live [3];
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state built from the requirements
  logic [1:0] mAcc [3];
  logic [2:0] mMode [3];
  logic       mBcd [3];
  logic       mWrHi [3];
  logic       mRdHi [3];
  logic [7:0] mHold [3];
  logic       mCH [3];
  logic [1:0] mCM [3];
  logic [15:0] mCV [3];
  logic       mSH [3];
  logic [7:0] mSV [3];

  always #2 clk = ~clk;
  assign liveCount = {live[2], live[1], live[0]};

  tmrPort dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .rdData(rdData), .loadStrobe(loadStrobe), .loadValue(loadValue), .liveCount(liveCount),
    .timerOut(timerOut), .chanMode(chanMode), .chanBcd(chanBcd)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic mdlReset();
    for (int c = 0; c < 3; c++) begin
      mAcc[c] = 2'd3; mMode[c] = 3'd0; mBcd[c] = 1'b0; mWrHi[c] = 1'b0; mRdHi[c] = 1'b0;
      mHold[c] = 8'h00; mCH[c] = 1'b0; mCM[c] = 2'd3; mCV[c] = 16'h0; mSH[c] = 1'b0; mSV[c] = 8'h0;
    end
  endtask

  function automatic logic [7:0] expRead(input int c);
    if (mSH[c]) return mSV[c];
    if (mCH[c]) return (mCM[c] == 2'd2) ? mCV[c][15:8] : mCV[c][7:0];
    if (mAcc[c] == 2'd2 || (mAcc[c] == 2'd3 && mRdHi[c])) return live[c][15:8];
    return live[c][7:0];
  endfunction

  task automatic mdlRdDone(input int c);
    if (mSH[c]) mSH[c] = 1'b0;
    else if (mCH[c]) begin
      if (mCM[c] == 2'd3) mCM[c] = 2'd2; else mCH[c] = 1'b0;
    end else if (mAcc[c] == 2'd3) mRdHi[c] = !mRdHi[c];
  endtask

  task automatic mdlFreezeCnt(input int c);
    if (!mCH[c]) begin mCH[c] = 1'b1; mCM[c] = mAcc[c]; mCV[c] = live[c]; end
  endtask

  task automatic mdlFreezeStat(input int c);
    if (!mSH[c]) begin
      mSH[c] = 1'b1;
      mSV[c] = {timerOut[c], 1'b0, mAcc[c], mMode[c], mBcd[c]};
    end
  endtask

  task automatic mdlCmd(input logic [7:0] d);
    int sel = int'(d[7:6]);
    if (sel == 3) begin
      for (int c = 0; c < 3; c++) if (d[c+1]) begin
        if (!d[5]) mdlFreezeCnt(c);
        if (!d[4]) mdlFreezeStat(c);
      end
    end else if (d[5:4] == 2'd0) begin
      mdlFreezeCnt(sel);
    end else begin
      mAcc[sel]  = d[5:4];
      mMode[sel] = (d[3:1] > 3'd5) ? {1'b0, d[2:1]} : d[3:1];
      mBcd[sel]  = d[0];
      mWrHi[sel] = 1'b0;
      mRdHi[sel] = 1'b0;
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d, input string tag);
    logic        expS;
    logic [15:0] expV;
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    #1;
    if (a == 2'd3) begin
      chk({tag, " no load on command"}, 16'(loadStrobe), 16'h0);
    end else begin
      expS = (mAcc[a] != 2'd3) || mWrHi[a];
      case (mAcc[a])
        2'd1:    expV = {8'h00, d};
        2'd2:    expV = {d, 8'h00};
        default: expV = {d, mHold[a]};
      endcase
      chk({tag, " load strobe"}, 16'(loadStrobe), expS ? 16'(3'b001 << a) : 16'h0);
      if (expS) chk({tag, " load value"}, loadValue[a*16 +: 16], expV);
    end
    @(posedge clk);
    if (a == 2'd3) mdlCmd(d);
    else if (mAcc[a] == 2'd3) begin
      if (!mWrHi[a]) mHold[a] = d;
      mWrHi[a] = !mWrHi[a];
    end
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 2'd3) begin
      chk("R2 mode outputs", 16'(chanMode), 16'({mMode[2], mMode[1], mMode[0]}));
      chk("R2 decimal outputs", 16'(chanBcd), 16'({mBcd[2], mBcd[1], mBcd[0]}));
    end
  endtask

  task automatic doRead(input logic [1:0] a, input int holdCycles, input string tag);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    for (int k = 0; k < holdCycles; k++) begin
      @(negedge clk);
      chk(tag, 16'(rdData), (a == 2'd3) ? 16'h0 : 16'(expRead(a)));
    end
    rdEn = 1'b0;
    @(posedge clk);
    if (a != 2'd3) mdlRdDone(a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1-chain actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    rstN = 1'b0; addr = 2'd0; wrData = 8'h00; wrEn = 1'b0; rdEn = 1'b0; timerOut = 3'b000;
    live[0] = 16'h1234; live[1] = 16'h5678; live[2] = 16'h9abc;
    mdlReset();
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    chk("R1 mode after reset", 16'(chanMode), 16'h0);
    chk("R1 decimal after reset", 16'(chanBcd), 16'h0);
    chk("R1 no load after reset", 16'(loadStrobe), 16'h0);
    doRead(2'd0, 1, "R1 live low first");
    doRead(2'd0, 1, "R1 live high second");

    // R2 control with folded mode 7 -> 3, channel 1 low-only, decimal
    doWrite(2'd3, 8'h5F, "R2");
    chk("R2 folded mode", 16'(chanMode[5:3]), 16'd3);
    chk("R2 decimal set", 16'(chanBcd[1]), 16'd1);

    // R3 low-only then high-only loads
    doWrite(2'd1, 8'hA5, "R3 low-only");
    doWrite(2'd3, 8'h64, "R2 high-only mode 2");
    doWrite(2'd1, 8'h3C, "R3 high-only");

    // R4 word write on channel 0
    doWrite(2'd0, 8'h11, "R4 first byte");
    doWrite(2'd0, 8'h22, "R4 second byte");
    doWrite(2'd0, 8'h33, "R4 pointer wrapped");
    doWrite(2'd0, 8'h44, "R4 second again");

    // R5 live reads in each order and the command address
    doRead(2'd1, 1, "R5 high-only live");
    doRead(2'd3, 1, "R5 command address reads zero");
    doRead(2'd2, 1, "R5 word low");
    doRead(2'd2, 1, "R5 word high");

    // R6 freeze channel 2, move the live count, read frozen bytes
    doWrite(2'd3, 8'h80, "R6 freeze");
    live[2] = 16'hFFEE;
    doRead(2'd2, 1, "R6 frozen low");
    doRead(2'd2, 1, "R6 frozen high");
    doRead(2'd2, 1, "R6 released live");

    // R7 second freeze ignored
    doWrite(2'd3, 8'h00, "R7 freeze ch0");
    live[0] = 16'hBEEF;
    doWrite(2'd3, 8'h00, "R7 repeat freeze");
    doRead(2'd0, 1, "R7 first value low");
    doRead(2'd0, 1, "R7 first value high");

    // R8/R9/R10: live pointer half-way, then multi-channel freeze of both items
    doRead(2'd0, 1, "R10 live low before freeze");
    timerOut = 3'b101;
    doWrite(2'd3, 8'hCE, "R8 read-back all");
    live[0] = 16'h0F0F; live[1] = 16'h7777; live[2] = 16'h2468; timerOut = 3'b010;
    doRead(2'd0, 1, "R9 status ch0");
    doRead(2'd0, 1, "R10 count low after status");
    doRead(2'd0, 1, "R10 count high after status");
    doRead(2'd0, 1, "R10 live resumes high");
    doRead(2'd1, 1, "R9 status ch1");
    doRead(2'd1, 1, "R8 count ch1");
    doRead(2'd2, 1, "R9 status ch2");
    doRead(2'd2, 1, "R8 count ch2 low");
    doRead(2'd2, 1, "R8 count ch2 high");
    chk("R9 expected status ch1 byte", 16'(mSV[1]), 16'h24);

    // R7 status-only freeze repeated with a changed output level
    doWrite(2'd3, 8'hE2, "R8 status only");
    timerOut = 3'b111;
    doWrite(2'd3, 8'hE2, "R7 status repeat");
    doRead(2'd0, 1, "R7 first status kept");
    doRead(2'd0, 1, "R10 live after status");

    // R11 held strobe keeps data and state
    doRead(2'd0, 4, "R11 held read");
    doRead(2'd0, 1, "R11 advanced once");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom % 5);
      case (op)
        0: doWrite(2'd3, 8'($urandom), "R2/R6/R8 random command");
        1: doWrite(2'($urandom % 3), 8'($urandom), "R3/R4 random write");
        2, 3: doRead(2'($urandom % 4), 1 + int'($urandom % 3), "R5/R10 random read");
        default: begin
          @(negedge clk);
          live[$urandom % 3] = 16'($urandom);
          timerOut = 3'($urandom);
        end
      endcase
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule